// File: doc/BRIEF.md
# CPU Clock Source Selector and Divider

This block produces the processor clock from one of five free-running sources: the main oscillator, the PLL output, a fast on-chip oscillator, a slow on-chip oscillator and the sub clock. A per-source gating channel switches between them without glitches. A gate-enable divider behind the source multiplexer then slows the selected clock by 1, 2, 4, 8 or 16. The sub clock always goes through undivided. A bus reference clock of the same frequency is also provided, and it is driven only while its active-low output-enable input is 0.

Configuration comes from a control domain clocked by `cfg_clk`. A source strobe loads the source code. A divide strobe loads the divide-by-8 override bit and the two-bit ratio field. Hardware sets the override bit on stop-mode entry. It also sets the bit when the main clock is stopped while the CPU runs from the sub clock (low-speed mode). Each gating channel is a two-state machine. In `CH_OFF` the *engage* transition to `CH_ON` happens when its synchronized request is high. In `CH_ON` the *release* transition back to `CH_OFF` happens when that request falls. A channel's request is raised only when no other channel is on.

Top module: `cpu_clk_gen`

## Requirements
- R1: Source codes are 0 main, 1 PLL, 2 fast oscillator, 3 slow oscillator, 4 sub clock, taken from `src_sel` on `src_load`. Codes 5 to 7 are ignored and leave the current source unchanged.
- R2: With the override bit at 0 and a non-sub source, `div_field` sets the output period: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 16 source periods.
- R3: With the override bit at 1 and a non-sub source, the output period is 8 source periods, whatever `div_field` holds.
- R4: With the sub clock selected, the output period equals the sub clock period, whatever the override bit and `div_field` hold.
- R5: During reset `cpu_clk` is low. After reset the slow oscillator is selected with divide-by-8, giving a period of 8 slow periods.
- R6: A `stop_entry` pulse sets the override bit, so the output changes to divide-by-8.
- R7: A `main_stop_ls` pulse while the sub clock is the selected source sets the override bit.
- R8: A `main_stop_ls` pulse while another source is selected has no effect.
- R9: A ratio change takes effect only at a divider terminal count. Every output period after the change equals either the old period or the new one.
- R10: During a source switch, no high or low pulse of `cpu_clk` is shorter than the shorter half-period of the two clocks involved.
- R11: With `bclk_oe_n` at 0, `bclk` follows `cpu_clk` and `bclk_en` is 1. With `bclk_oe_n` at 1, `bclk` and `bclk_en` are 0.
- R12: At most one source is gated on at any time, so every high pulse of `cpu_clk` is exactly one high half-period of a single source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Control-domain clock for configuration and strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_main | input | 1 | Main oscillator clock (code 0) |
| clk_pll | input | 1 | PLL output clock (code 1) |
| clk_fast | input | 1 | Fast on-chip oscillator clock (code 2) |
| clk_slow | input | 1 | Slow on-chip oscillator clock (code 3) |
| clk_sub | input | 1 | Sub clock (code 4) |
| src_load | input | 1 | Strobe that loads `src_sel` |
| src_sel | input | 3 | Source code |
| div_load | input | 1 | Strobe that loads `div8_in` and `div_field` |
| div8_in | input | 1 | Divide-by-8 override value |
| div_field | input | 2 | Two-bit ratio field |
| stop_entry | input | 1 | Stop-mode entry strobe |
| main_stop_ls | input | 1 | Main-clock stop request strobe |
| bclk_oe_n | input | 1 | Active-low bus clock output enable |
| cpu_clk | output | 1 | Divided CPU clock |
| bclk | output | 1 | Bus reference clock |
| bclk_en | output | 1 | Bus clock driver enable |

## Verification
The assertions assume that all five source clocks keep toggling whenever reset is released. They also assume every strobe is a single `cfg_clk` cycle driven in that domain, and that a new source is not requested until the previous switch has finished. The handshake, the countdown checks and the one-hot check only hold under those conditions. The stimulus runs every source clock continuously and drives strobes on the falling edge of `cfg_clk`. After every load it waits several `cpu_clk` rising edges before it measures or loads again.

// File: rtl/cpu_clk_pkg.sv
`timescale 1ns/1ps
package cpu_clk_pkg;
    localparam int NUM_SRC   = 5;
    localparam int SRC_W     = 3;
    localparam int MAX_SHIFT = 4;
    localparam int SHIFT_W   = 3;
    localparam int CNT_W     = MAX_SHIFT;
    localparam int DIV8_SHIFT = 3;

    typedef enum logic [SRC_W-1:0] {
        SRC_MAIN = 3'd0,
        SRC_PLL  = 3'd1,
        SRC_FAST = 3'd2,
        SRC_SLOW = 3'd3,
        SRC_SUB  = 3'd4
    } src_e;

    typedef enum logic {
        CH_OFF = 1'b0,
        CH_ON  = 1'b1
    } ch_state_e;

    // log2 of the effective divide ratio
    function automatic logic [SHIFT_W-1:0] ratio_shift(input src_e s, input logic d8,
                                                       input logic [1:0] f);
        logic [SHIFT_W-1:0] r;
        if (s == SRC_SUB) begin
            r = '0;
        end else if (d8) begin
            r = SHIFT_W'(DIV8_SHIFT);
        end else begin
            case (f)
                2'b00:   r = SHIFT_W'(0);
                2'b01:   r = SHIFT_W'(1);
                2'b10:   r = SHIFT_W'(2);
                default: r = SHIFT_W'(MAX_SHIFT);
            endcase
        end
        return r;
    endfunction
endpackage

// File: rtl/cpu_clk_cfg.sv
`timescale 1ns/1ps
module cpu_clk_cfg
    import cpu_clk_pkg::*;
(
    input  logic                 cfg_clk,
    input  logic                 rst_n,
    input  logic                 src_load,
    input  logic [SRC_W-1:0]     src_sel,
    input  logic                 div_load,
    input  logic                 div8_in,
    input  logic [1:0]           div_field,
    input  logic                 stop_entry,
    input  logic                 main_stop_ls,
    output logic [NUM_SRC-1:0]   sel_oh,
    output logic [SHIFT_W-1:0]   shift_code
);
    src_e       src_q;
    logic       div8_q;
    logic [1:0] field_q;
    logic       force_div8;

    assign force_div8 = stop_entry || (main_stop_ls && (src_q == SRC_SUB));

    always_ff @(posedge cfg_clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q      <= SRC_SLOW;
            div8_q     <= 1'b1;
            field_q    <= 2'b00;
            sel_oh     <= NUM_SRC'(1) << SRC_SLOW;
            shift_code <= SHIFT_W'(DIV8_SHIFT);
        end else begin
            if (src_load && (src_sel <= SRC_W'(SRC_SUB))) begin
                src_q <= src_e'(src_sel);
            end
            if (force_div8) begin
                div8_q <= 1'b1;
            end else if (div_load) begin
                div8_q <= div8_in;
            end
            if (div_load) begin
                field_q <= div_field;
            end
            sel_oh     <= NUM_SRC'(1) << src_q;
            shift_code <= ratio_shift(src_q, div8_q, field_q);
        end
    end

    assert_bad_code_hold_R1: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        (src_load && (src_sel > SRC_W'(SRC_SUB))) |=> $stable(src_q))
        else $error("R1: reserved source code changed the selection");

    assert_stop_sets_div8_R6: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        stop_entry |=> div8_q)
        else $error("R6: stop entry did not set the override");

    assert_lowspeed_stop_R7: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        (main_stop_ls && (src_q == SRC_SUB)) |=> div8_q)
        else $error("R7: main stop in low-speed mode did not set the override");
endmodule

// File: rtl/cpu_clk_chan.sv
`timescale 1ns/1ps
module cpu_clk_chan
    import cpu_clk_pkg::*;
#(
    parameter bit RESET_ON = 1'b0
) (
    input  logic clk_src,
    input  logic rst_n,
    input  logic req,
    output logic on,
    output logic gated
);
    logic      req_s1, req_s2;
    ch_state_e state_q, state_nx;

    // two-flop synchronizer on the falling edge of the own clock
    always_ff @(negedge clk_src or negedge rst_n) begin
        if (!rst_n) begin
            req_s1 <= RESET_ON;
            req_s2 <= RESET_ON;
        end else begin
            req_s1 <= req;
            req_s2 <= req_s1;
        end
    end

    always_ff @(negedge clk_src or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RESET_ON ? CH_ON : CH_OFF;
        end else begin
            state_q <= state_nx;
        end
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            CH_OFF: if (req_s2)  state_nx = CH_ON;   // engage
            CH_ON:  if (!req_s2) state_nx = CH_OFF;  // release
        endcase
    end

    always_comb begin
        on    = (state_q == CH_ON);
        gated = clk_src & on;
    end
endmodule

// File: rtl/cpu_clk_div.sv
`timescale 1ns/1ps
module cpu_clk_div
    import cpu_clk_pkg::*;
(
    input  logic               clk_src,
    input  logic               rst_n,
    input  logic [SHIFT_W-1:0] shift_in,
    output logic               gate_en
);
    logic [SHIFT_W-1:0] sh_s1, sh_s2, sh_act;
    logic [CNT_W-1:0]   cnt_q, cnt_nx;

    function automatic logic [CNT_W-1:0] limit_of(input logic [SHIFT_W-1:0] sh);
        logic [CNT_W:0] pow;
        pow = (CNT_W+1)'(1) << sh;
        return CNT_W'(pow - (CNT_W+1)'(1));
    endfunction

    always_comb begin
        if (cnt_q == '0) begin
            cnt_nx = (sh_s1 == sh_s2) ? limit_of(sh_s2) : limit_of(sh_act);
        end else begin
            cnt_nx = cnt_q - 1'b1;
        end
    end

    always_ff @(negedge clk_src or negedge rst_n) begin
        if (!rst_n) begin
            sh_s1   <= SHIFT_W'(DIV8_SHIFT);
            sh_s2   <= SHIFT_W'(DIV8_SHIFT);
            sh_act  <= SHIFT_W'(DIV8_SHIFT);
            cnt_q   <= '0;
            gate_en <= 1'b0;
        end else begin
            sh_s1 <= shift_in;
            sh_s2 <= sh_s1;
            if ((cnt_q == '0) && (sh_s1 == sh_s2)) begin
                sh_act <= sh_s2;
            end
            cnt_q   <= cnt_nx;
            gate_en <= (cnt_nx == '0);
        end
    end

    assert_countdown_R9: assert property (@(negedge clk_src) disable iff (!rst_n)
        (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1))
        else $error("R9: ratio reloaded before terminal count");

    assert_pulse_at_terminal_R9: assert property (@(negedge clk_src) disable iff (!rst_n)
        gate_en |-> (cnt_q == '0))
        else $error("R9: output pulse away from terminal count");
endmodule

// File: rtl/cpu_clk_gen.sv
`timescale 1ns/1ps
module cpu_clk_gen
    import cpu_clk_pkg::*;
(
    input  logic       cfg_clk,
    input  logic       rst_n,
    input  logic       clk_main,
    input  logic       clk_pll,
    input  logic       clk_fast,
    input  logic       clk_slow,
    input  logic       clk_sub,
    input  logic       src_load,
    input  logic [2:0] src_sel,
    input  logic       div_load,
    input  logic       div8_in,
    input  logic [1:0] div_field,
    input  logic       stop_entry,
    input  logic       main_stop_ls,
    input  logic       bclk_oe_n,
    output logic       cpu_clk,
    output logic       bclk,
    output logic       bclk_en
);
    logic [NUM_SRC-1:0] src_clks, sel_oh, req_vec, on_vec, gated_vec;
    logic [SHIFT_W-1:0] shift_code;
    logic               mux_clk, gate_en;

    assign src_clks = {clk_sub, clk_slow, clk_fast, clk_pll, clk_main};

    cpu_clk_cfg u_cfg (
        .cfg_clk      (cfg_clk),
        .rst_n        (rst_n),
        .src_load     (src_load),
        .src_sel      (src_sel),
        .div_load     (div_load),
        .div8_in      (div8_in),
        .div_field    (div_field),
        .stop_entry   (stop_entry),
        .main_stop_ls (main_stop_ls),
        .sel_oh       (sel_oh),
        .shift_code   (shift_code)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_chan
        logic others_on;
        assign others_on  = |(on_vec & ~(NUM_SRC'(1) << i));
        assign req_vec[i] = sel_oh[i] & ~others_on;

        cpu_clk_chan #(.RESET_ON(i == int'(SRC_SLOW))) u_chan (
            .clk_src (src_clks[i]),
            .rst_n   (rst_n),
            .req     (req_vec[i]),
            .on      (on_vec[i]),
            .gated   (gated_vec[i])
        );
    end

    assign mux_clk = |gated_vec;

    cpu_clk_div u_div (
        .clk_src  (mux_clk),
        .rst_n    (rst_n),
        .shift_in (shift_code),
        .gate_en  (gate_en)
    );

    always_comb begin
        cpu_clk = mux_clk & gate_en;
        bclk_en = ~bclk_oe_n;
        bclk    = bclk_oe_n ? 1'b0 : cpu_clk;
    end

    assert_single_source_R12: assert property (@(posedge cfg_clk) disable iff (!rst_n)
        $onehot0(on_vec))
        else $error("R12: two sources gated on together");
endmodule

// File: tb/test_cpu_clk_gen.sv
`timescale 1ns/1ps
module test_cpu_clk_gen;
    logic cfg_clk = 0, rst_n = 0;
    logic clk_main = 0, clk_pll = 0, clk_fast = 0, clk_slow = 0, clk_sub = 0;
    logic src_load = 0, div_load = 0, div8_in = 0, stop_entry = 0, main_stop_ls = 0;
    logic bclk_oe_n = 0;
    logic [2:0] src_sel = 3'd0;
    logic [1:0] div_field = 2'd0;
    logic cpu_clk, bclk, bclk_en;

    int  checks = 0, errors = 0;
    bit  done = 0;
    real t_rise = -1.0, t_fall = -1.0, min_w = 1.0e9;
    int  bad_high = 0, win_id = 0, seen_id = 0;

    always #5  cfg_clk  = ~cfg_clk;
    always #10 clk_main = ~clk_main;
    always #4  clk_pll  = ~clk_pll;
    always #6  clk_fast = ~clk_fast;
    always #20 clk_slow = ~clk_slow;
    always #30 clk_sub  = ~clk_sub;

    cpu_clk_gen i_cpu_clk_gen (
        .cfg_clk(cfg_clk), .rst_n(rst_n), .clk_main(clk_main), .clk_pll(clk_pll),
        .clk_fast(clk_fast), .clk_slow(clk_slow), .clk_sub(clk_sub),
        .src_load(src_load), .src_sel(src_sel), .div_load(div_load), .div8_in(div8_in),
        .div_field(div_field), .stop_entry(stop_entry), .main_stop_ls(main_stop_ls),
        .bclk_oe_n(bclk_oe_n), .cpu_clk(cpu_clk), .bclk(bclk), .bclk_en(bclk_en)
    );

    // {src, override, field, expected period in ns}
    localparam logic [21:0] VEC [22] = '{
        {3'd0, 1'b0, 2'd0, 16'd20},  {3'd0, 1'b0, 2'd1, 16'd40},
        {3'd0, 1'b0, 2'd2, 16'd80},  {3'd0, 1'b0, 2'd3, 16'd320},
        {3'd0, 1'b1, 2'd3, 16'd160}, {3'd1, 1'b0, 2'd0, 16'd8},
        {3'd1, 1'b0, 2'd1, 16'd16},  {3'd1, 1'b0, 2'd2, 16'd32},
        {3'd1, 1'b0, 2'd3, 16'd128}, {3'd1, 1'b1, 2'd1, 16'd64},
        {3'd2, 1'b0, 2'd0, 16'd12},  {3'd2, 1'b0, 2'd1, 16'd24},
        {3'd2, 1'b0, 2'd2, 16'd48},  {3'd2, 1'b0, 2'd3, 16'd192},
        {3'd2, 1'b1, 2'd0, 16'd96},  {3'd3, 1'b0, 2'd0, 16'd40},
        {3'd3, 1'b0, 2'd1, 16'd80},  {3'd3, 1'b0, 2'd2, 16'd160},
        {3'd3, 1'b0, 2'd3, 16'd640}, {3'd3, 1'b1, 2'd2, 16'd320},
        {3'd4, 1'b1, 2'd3, 16'd60},  {3'd4, 1'b0, 2'd2, 16'd60}
    };

    function automatic bit near(input real a, input real b);
        return (a - b < 0.01) && (b - a < 0.01);
    endfunction

    function automatic real half_of(input int s);
        case (s)
            0: return 10.0;
            1: return 4.0;
            2: return 6.0;
            3: return 20.0;
            default: return 30.0;
        endcase
    endfunction

    // pulse monitor: minimum pulse width and high pulses not matching a single source
    always @(cpu_clk) begin
        if (win_id != seen_id) begin
            seen_id  = win_id;
            min_w    = 1.0e9;
            bad_high = 0;
        end
        if (rst_n) begin
            if (cpu_clk) begin
                if (t_fall >= 0.0 && $realtime - t_fall < min_w) min_w = $realtime - t_fall;
                t_rise = $realtime;
            end else begin
                if (t_rise >= 0.0) begin
                    if ($realtime - t_rise < min_w) min_w = $realtime - t_rise;
                    if (!(near($realtime - t_rise, 4.0) || near($realtime - t_rise, 6.0) ||
                          near($realtime - t_rise, 10.0) || near($realtime - t_rise, 20.0) ||
                          near($realtime - t_rise, 30.0)))
                        bad_high++;
                end
                t_fall = $realtime;
            end
        end
    end

    task automatic check(input bit ok, input string req, input real act, input real exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0.3f expected %0.3f", req, act, exp);
        end
    endtask

    task automatic wait_edges(input int n);
        for (int k = 0; k < n; k++) @(posedge cpu_clk);
    endtask

    task automatic measure(output real p);
        real t0;
        @(posedge cpu_clk);
        t0 = $realtime;
        @(posedge cpu_clk);
        p = $realtime - t0;
    endtask

    task automatic load_src(input logic [2:0] s);
        @(negedge cfg_clk);
        src_sel = s; src_load = 1'b1;
        @(negedge cfg_clk);
        src_load = 1'b0;
    endtask

    task automatic load_all(input logic [2:0] s, input logic d8, input logic [1:0] f);
        @(negedge cfg_clk);
        src_sel = s; src_load = 1'b1; div8_in = d8; div_field = f; div_load = 1'b1;
        @(negedge cfg_clk);
        src_load = 1'b0; div_load = 1'b0;
    endtask

    task automatic pulse(input bit which_stop);
        @(negedge cfg_clk);
        if (which_stop) stop_entry = 1'b1; else main_stop_ls = 1'b1;
        @(negedge cfg_clk);
        stop_entry = 1'b0; main_stop_ls = 1'b0;
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        real p;
        int  prev;
        int  order [6] = '{1, 3, 2, 4, 0, 1};

        // R5: reset state
        for (int k = 0; k < 5; k++) begin
            #37;
            check(cpu_clk == 1'b0, "R5 cpu_clk low in reset", real'(cpu_clk), 0.0);
        end
        @(negedge cfg_clk);
        rst_n = 1'b1;
        wait_edges(1);
        measure(p);
        check(near(p, 320.0), "R5 slow/8 after reset", p, 320.0);

        // R2 R3 R4 R1: table walk
        for (int k = 0; k < 22; k++) begin
            load_all(VEC[k][21:19], VEC[k][18], VEC[k][17:16]);
            wait_edges(3);
            for (int m = 0; m < 2; m++) begin
                measure(p);
                check(near(p, real'(VEC[k][15:0])), "R1 R2 R3 R4 period", p,
                      real'(VEC[k][15:0]));
            end
        end

        // R1: reserved code ignored (sub/1 stays)
        load_src(3'd6);
        wait_edges(3);
        measure(p);
        check(near(p, 60.0), "R1 reserved code ignored", p, 60.0);

        // R7: main stop on sub sets override
        load_all(3'd4, 1'b0, 2'd0);
        wait_edges(3);
        pulse(1'b0);
        load_src(3'd0);
        wait_edges(4);
        measure(p);
        check(near(p, 160.0), "R7 low-speed main stop forces /8", p, 160.0);

        // R8: main stop on a non-sub source has no effect
        load_all(3'd0, 1'b0, 2'd0);
        wait_edges(4);
        pulse(1'b0);
        wait_edges(12);
        measure(p);
        check(near(p, 20.0), "R8 main stop ignored off sub", p, 20.0);

        // R6: stop entry forces /8
        pulse(1'b1);
        wait_edges(3);
        measure(p);
        check(near(p, 160.0), "R6 stop entry forces /8", p, 160.0);

        // R9: ratio change only at terminal count
        load_all(3'd0, 1'b0, 2'd3);
        wait_edges(3);
        #77;
        load_all(3'd0, 1'b0, 2'd1);
        for (int m = 0; m < 6; m++) begin
            measure(p);
            check(near(p, 320.0) || near(p, 40.0), "R9 period old or new", p, 40.0);
        end
        measure(p);
        check(near(p, 40.0), "R9 new ratio in effect", p, 40.0);

        // R10 R12: source switches at divide-by-1
        load_all(3'd1, 1'b0, 2'd0);
        wait_edges(6);
        for (int k = 0; k < 5; k++) begin
            prev = order[k];
            win_id++;
            load_src(3'(order[k + 1]));
            wait_edges(8);
            #1;
            check(min_w >= ((half_of(prev) < half_of(order[k + 1])) ? half_of(prev)
                            : half_of(order[k + 1])) - 0.01,
                  "R10 no runt pulse on switch", min_w,
                  (half_of(prev) < half_of(order[k + 1])) ? half_of(prev)
                  : half_of(order[k + 1]));
            check(bad_high == 0, "R12 single-source high pulses", real'(bad_high), 0.0);
        end

        // R11: bus clock and its enable
        for (int k = 0; k < 6; k++) begin
            #3;
            check(bclk == cpu_clk, "R11 bclk follows cpu_clk", real'(bclk), real'(cpu_clk));
        end
        check(bclk_en == 1'b1, "R11 enable on", real'(bclk_en), 1.0);
        bclk_oe_n = 1'b1;
        for (int k = 0; k < 6; k++) begin
            #3;
            check(bclk == 1'b0, "R11 bclk held low", real'(bclk), 0.0);
        end
        check(bclk_en == 1'b0, "R11 enable off", real'(bclk_en), 0.0);
        bclk_oe_n = 1'b0;

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule